// File: doc/BRIEF.md
# Multi-Table Hashed Longest-Prefix Lookup Engine

This block resolves a 32-bit destination address to a next-hop value by longest-prefix match. It does not sort prefixes into per-length tables. Prefixes of every length share three hash tables, and each table holds buckets of four entries. Every table has its own index generator. Each generator folds the same window of twelve address bits into a 6-bit bucket index, and each table uses a different fold. On each lookup the engine reads one bucket from every table in the same cycle. Twelve match units then compare all fetched entries with the key in parallel, and a reduction stage picks the longest valid match.

Searches enter on a valid/ready request channel at up to one per cycle. Results leave on a valid/ready result channel, in request order, carrying a hit flag and the next-hop value. The pipeline advances only when the result register is empty or is being taken. When the consumer holds `res_ready` low while a result is pending, the whole pipeline freezes, `req_ready` drops in the same cycle, and the pending result stays unchanged. An external controller loads the tables through a plain write port. That controller also decides where each prefix goes, and it expands a prefix whose wildcard bits fall inside the index window.

Top module: `lkp_engine`

## Requirements
- R1: After reset every stored entry is invalid, `res_valid` is low and `req_ready` is high, so any lookup that follows reports a miss.
- R2: A write with `wr_en` high stores `wr_vld`, `wr_pfx`, `wr_len` and `wr_nh` at table `wr_tab`, bucket `wr_idx`, way `wr_way` on the clock edge. Writing with `wr_vld` low removes that entry from all later lookups.
- R3: The bucket read from table t is computed from s = addr[26:15]. The index is rotl6(s[11:6], t) XOR s[5:0], where rotl6 rotates a 6-bit value left. An entry stored at any other bucket is never found for that address.
- R4: An entry matches when it is valid, its length L is 32 or less, and the top L bits of the key equal the top L bits of its prefix. An entry with a length above 32 never matches.
- R5: Among all matching entries in all tables, the result carries the next hop of the entry with the greatest length, whatever table holds it.
- R6: When matching entries tie on length, the entry in the lowest-numbered table wins. Within one table, the lowest-numbered way wins.
- R7: A lookup with no matching entry reports `res_hit` low and `res_nh` equal to zero.
- R8: With `res_ready` held high, a request accepted on one clock edge gives its result on `res_valid` exactly three edges later, and one request is accepted every cycle.
- R9: While `res_valid` is high and `res_ready` is low, `res_hit` and `res_nh` hold their values and `req_ready` is low. Every accepted request yields exactly one result, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Search request present |
| req_ready | output | 1 | Engine can accept a search this cycle |
| req_addr | input | 32 | Destination address to search |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Consumer takes the result this cycle |
| res_hit | output | 1 | A stored prefix matched |
| res_nh | output | 8 | Next hop of the longest match, zero on a miss |
| wr_en | input | 1 | Table write strobe |
| wr_tab | input | 2 | Table selected for the write |
| wr_idx | input | 6 | Bucket selected for the write |
| wr_way | input | 2 | Entry within the bucket |
| wr_vld | input | 1 | Valid flag written to the entry |
| wr_pfx | input | 32 | Prefix value written |
| wr_len | input | 6 | Prefix length written |
| wr_nh | input | 8 | Next hop written |

## Verification
The bench places one address's prefixes of lengths 8, 16, 24 and 32 across different tables. It then flips address bits that lie inside some prefixes but outside the index window. A design that compared the wrong number of top bits, or that preferred a table over a longer match, would return the wrong next hop here. Directed ties across tables and across ways catch a reversed priority order. An entry with a length above 32 catches a mask that wraps, and an entry written one bucket away catches an index generator with a wrong rotation. Two streams of about three hundred lookups run against the same table contents, one with no back-pressure and one with a pseudo-random `res_ready`. A design that dropped, duplicated or reordered results, changed a held result, or took more or fewer than three cycles would fail those streams.

// File: rtl/lkp_pkg.sv
package lkp_pkg;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 6;
  localparam int NH_W   = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] pfx;
    logic [LEN_W-1:0]  len;
    logic [NH_W-1:0]   nh;
  } pay_t;

  typedef struct packed {
    logic vld;
    pay_t pay;
  } entry_t;
endpackage

// File: rtl/lkp_hash.sv
module lkp_hash #(
  parameter int IDX_W   = 6,
  parameter int TAB     = 0,
  parameter int SEL_TOP = 26,
  parameter int ADDR_W  = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int SEL_W = 2 * IDX_W;
  localparam int ROT   = TAB % IDX_W;

  logic [SEL_W-1:0] sel;
  logic [IDX_W-1:0] hi, lo, hi_rot;

  assign sel = addr[SEL_TOP -: SEL_W];
  assign hi  = sel[SEL_W-1:IDX_W];
  assign lo  = sel[IDX_W-1:0];

  // each table folds the same window with a different rotation of the upper half
  generate
    if (ROT == 0) begin : g_plain
      assign hi_rot = hi;
    end else begin : g_rot
      assign hi_rot = {hi[IDX_W-1-ROT:0], hi[IDX_W-1:IDX_W-ROT]};
    end
  endgenerate

  assign idx = hi_rot ^ lo;
endmodule

// File: rtl/lkp_table.sv
module lkp_table
  import lkp_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [WAY_W-1:0]       wr_way,
  input  entry_t                 wr_ent,
  input  logic                   rd_en,
  input  logic [IDX_W-1:0]       rd_idx,
  output entry_t [WAYS-1:0]      rd_bkt
);
  localparam int DEPTH = 1 << IDX_W;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [DEPTH-1:0] vbits;
      pay_t             mem [DEPTH];
      entry_t           q;
      logic             we;

      assign we = wr_en && (wr_way == WAY_W'(w));

      always_ff @(posedge clk) begin
        if (!rst_n) vbits <= '0;
        else if (we) vbits[wr_idx] <= wr_ent.vld;
      end

      always_ff @(posedge clk) begin
        if (we) mem[wr_idx] <= wr_ent.pay;
      end

      always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else if (rd_en) begin
          q.vld <= vbits[rd_idx];
          q.pay <= mem[rd_idx];
        end
      end

      assign rd_bkt[w] = q;
    end
  endgenerate
endmodule

// File: rtl/lkp_match.sv
module lkp_match
  import lkp_pkg::*;
#(
  parameter int NSLOT = 12
) (
  input  logic [ADDR_W-1:0]   key,
  input  entry_t [NSLOT-1:0]  slot,
  output logic                hit,
  output logic [NH_W-1:0]     nh
);
  localparam logic [LEN_W:0] MAX_LEN = (LEN_W+1)'(ADDR_W);

  logic [NSLOT-1:0] m;

  generate
    for (genvar i = 0; i < NSLOT; i++) begin : g_cmp
      logic [ADDR_W-1:0] mask;
      assign mask = ~({ADDR_W{1'b1}} >> slot[i].pay.len);
      assign m[i] = slot[i].vld
                 && ({1'b0, slot[i].pay.len} <= MAX_LEN)
                 && (((key ^ slot[i].pay.pfx) & mask) == '0);
    end
  endgenerate

  // slots are ordered table-major, so a strict compare keeps the lowest table/way on ties
  always_comb begin
    logic [LEN_W-1:0] best;
    best = '0;
    hit  = 1'b0;
    nh   = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (m[i] && (!hit || slot[i].pay.len > best)) begin
        hit  = 1'b1;
        best = slot[i].pay.len;
        nh   = slot[i].pay.nh;
      end
    end
  end
endmodule

// File: rtl/lkp_engine.sv
module lkp_engine
  import lkp_pkg::*;
#(
  parameter int NTAB    = 3,
  parameter int WAYS    = 4,
  parameter int IDX_W   = 6,
  parameter int SEL_TOP = 26,
  parameter int TAB_W   = 2,
  parameter int WAY_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               res_valid,
  input  logic               res_ready,
  output logic               res_hit,
  output logic [NH_W-1:0]    res_nh,
  input  logic               wr_en,
  input  logic [TAB_W-1:0]   wr_tab,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [WAY_W-1:0]   wr_way,
  input  logic               wr_vld,
  input  logic [ADDR_W-1:0]  wr_pfx,
  input  logic [LEN_W-1:0]   wr_len,
  input  logic [NH_W-1:0]    wr_nh
);
  localparam int NSLOT = NTAB * WAYS;

  logic adv;
  assign adv       = !res_valid || res_ready;
  assign req_ready = adv;

  entry_t wr_ent;
  assign wr_ent.vld     = wr_vld;
  assign wr_ent.pay.pfx = wr_pfx;
  assign wr_ent.pay.len = wr_len;
  assign wr_ent.pay.nh  = wr_nh;

  // stage 1: index generation
  logic [IDX_W-1:0]  idx_c [NTAB];
  logic [IDX_W-1:0]  s1_idx [NTAB];
  logic              s1_v, s2_v;
  logic [ADDR_W-1:0] s1_key, s2_key;

  entry_t [WAYS-1:0]  bkt [NTAB];
  entry_t [NSLOT-1:0] slots;

  generate
    for (genvar t = 0; t < NTAB; t++) begin : g_tab
      lkp_hash #(.IDX_W(IDX_W), .TAB(t), .SEL_TOP(SEL_TOP), .ADDR_W(ADDR_W)) u_hash (
        .addr (req_addr),
        .idx  (idx_c[t])
      );

      always_ff @(posedge clk) begin
        if (!rst_n) s1_idx[t] <= '0;
        else if (adv) s1_idx[t] <= idx_c[t];
      end

      // stage 2: bucket fetch
      lkp_table #(.IDX_W(IDX_W), .WAYS(WAYS), .WAY_W(WAY_W)) u_tab (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en && (wr_tab == TAB_W'(t))),
        .wr_idx (wr_idx),
        .wr_way (wr_way),
        .wr_ent (wr_ent),
        .rd_en  (adv),
        .rd_idx (s1_idx[t]),
        .rd_bkt (bkt[t])
      );

      for (genvar w = 0; w < WAYS; w++) begin : g_slot
        assign slots[t*WAYS + w] = bkt[t][w];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v   <= 1'b0;
      s2_v   <= 1'b0;
      s1_key <= '0;
      s2_key <= '0;
    end else if (adv) begin
      s1_v   <= req_valid;
      s1_key <= req_addr;
      s2_v   <= s1_v;
      s2_key <= s1_key;
    end
  end

  // stage 3: parallel compare and longest-match reduction
  logic            m_hit;
  logic [NH_W-1:0] m_nh;

  lkp_match #(.NSLOT(NSLOT)) u_match (
    .key  (s2_key),
    .slot (slots),
    .hit  (m_hit),
    .nh   (m_nh)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_nh    <= '0;
    end else if (adv) begin
      res_valid <= s2_v;
      res_hit   <= s2_v && m_hit;
      res_nh    <= (s2_v && m_hit) ? m_nh : '0;
    end
  end
endmodule

// File: rtl/lkp_engine_chk.sv
module lkp_engine_chk
  import lkp_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            res_valid,
  input logic            res_ready,
  input logic            res_hit,
  input logic [NH_W-1:0] res_nh
);
  logic [3:0] inflight;
  logic       acc, dlv;
  assign acc = req_valid && req_ready;
  assign dlv = res_valid && res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + {3'b0, acc} - {3'b0, dlv};
  end

  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_hit) && $stable(res_nh));

  a_r9_stall_blocks_req: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !req_ready);

  a_r9_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> inflight != 4'd0);

  a_r8_depth: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 4'd3);

  a_r7_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_hit |-> res_nh == '0);
endmodule

bind lkp_engine lkp_engine_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_hit   (res_hit),
  .res_nh    (res_nh)
);

// File: tb/lkp_engine_tb.sv
module lkp_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic        res_valid, res_ready = 1'b1, res_hit;
  logic [7:0]  res_nh;
  logic        wr_en = 1'b0, wr_vld = 1'b0;
  logic [1:0]  wr_tab = '0, wr_way = '0;
  logic [5:0]  wr_idx = '0, wr_len = '0;
  logic [31:0] wr_pfx = '0;
  logic [7:0]  wr_nh = '0;

  always #2 clk = ~clk;

  lkp_engine dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .res_valid(res_valid), .res_ready(res_ready),
    .res_hit(res_hit), .res_nh(res_nh), .wr_en(wr_en), .wr_tab(wr_tab),
    .wr_idx(wr_idx), .wr_way(wr_way), .wr_vld(wr_vld), .wr_pfx(wr_pfx),
    .wr_len(wr_len), .wr_nh(wr_nh)
  );

  int total = 0, bad = 0;
  bit done = 0;

  // bench-side shadow of what was written
  logic        mv [3][64][4];
  logic [31:0] mp [3][64][4];
  logic [5:0]  ml [3][64][4];
  logic [7:0]  mn [3][64][4];
  logic [31:0] la [0:511];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] bm(input int l);
    return (l == 0) ? 32'h0 : ~(32'hFFFF_FFFF >> l);
  endfunction

  function automatic logic [5:0] bh(input logic [31:0] a, input int t);
    logic [11:0] s;
    logic [5:0]  hi, r;
    s  = a[26:15];
    hi = s[11:6];
    r  = (hi << t) | (hi >> (6 - t));
    return r ^ s[5:0];
  endfunction

  function automatic logic [8:0] model(input logic [31:0] a);
    logic h; logic [5:0] bl; logic [7:0] n;
    h = 0; bl = 0; n = 0;
    for (int t = 0; t < 3; t++)
      for (int w = 0; w < 4; w++) begin
        logic [5:0] ix;
        ix = bh(a, t);
        if (mv[t][ix][w] && ml[t][ix][w] <= 6'd32 &&
            (((a ^ mp[t][ix][w]) & bm(int'(ml[t][ix][w]))) == 0) &&
            (!h || ml[t][ix][w] > bl)) begin
          h = 1; bl = ml[t][ix][w]; n = mn[t][ix][w];
        end
      end
    return {h, n};
  endfunction

  task automatic clear_model();
    for (int t = 0; t < 3; t++)
      for (int i = 0; i < 64; i++)
        for (int w = 0; w < 4; w++) mv[t][i][w] = 0;
  endtask

  task automatic wr(input int t, input logic [5:0] ix, input int w, input bit v,
                    input logic [31:0] p, input logic [5:0] l, input logic [7:0] n);
    @(negedge clk);
    wr_en = 1; wr_tab = 2'(t); wr_idx = ix; wr_way = 2'(w); wr_vld = v;
    wr_pfx = p; wr_len = l; wr_nh = n;
    mv[t][ix][w] = v; mp[t][ix][w] = p; ml[t][ix][w] = l; mn[t][ix][w] = n;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic look1(input logic [31:0] a, input bit eh, input logic [7:0] en,
                       input string tag);
    @(negedge clk);
    res_ready = 1; req_valid = 1; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    @(negedge clk);
    chk(res_valid == 1'b1, tag, "res_valid", 64'(res_valid), 64'd1);
    chk(res_hit == eh && res_nh == en, tag, "hit/nh", {55'd0, res_hit, res_nh}, {55'd0, eh, en});
  endtask

  task automatic run_batch(input int n, input bit bp);
    int sent, rc, cyc;
    bit pst;
    logic ph; logic [7:0] pn;
    logic [31:0] lf;
    logic [8:0] ex [0:511];
    int st [0:511];
    sent = 0; rc = 0; cyc = 0; pst = 0; ph = 0; pn = 0; lf = 32'h1;
    while (rc < n && cyc < 20000) begin
      @(negedge clk);
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      res_ready = bp ? (lf[3] | lf[7]) : 1'b1;
      req_valid = (sent < n);
      req_addr  = (sent < n) ? la[sent] : 32'h0;
      #1;
      if (pst) begin // R9 held result
        chk(res_valid && res_hit == ph && res_nh == pn, "R9", "held result",
            {55'd0, res_hit, res_nh}, {55'd0, ph, pn});
      end
      if (res_valid && !res_ready)
        chk(!req_ready, "R9", "req_ready under stall", 64'(req_ready), 64'd0);
      pst = res_valid && !res_ready; ph = res_hit; pn = res_nh;
      if (res_valid && res_ready) begin
        chk({res_hit, res_nh} == ex[rc], "R5", "stream result",
            {55'd0, res_hit, res_nh}, {55'd0, ex[rc]});
        if (!bp) chk(cyc - st[rc] == 3, "R8", "latency", 64'(cyc - st[rc]), 64'd3);
        rc++;
      end
      if (req_valid && req_ready) begin
        ex[sent] = model(la[sent]);
        st[sent] = cyc;
        sent++;
      end else if (!bp && req_valid) begin
        chk(0, "R8", "req_ready low without back-pressure", 64'(req_ready), 64'd1);
      end
      cyc++;
    end
    req_valid = 0; res_ready = 1;
    chk(rc == n, "R9", "result count", 64'(rc), 64'(n));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, a2, lf;
    int k;
    clear_model();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(res_valid == 0 && req_ready == 1, "R1", "reset state",
        {62'd0, res_valid, req_ready}, 64'd1);
    a = 32'hC0A8_5A37;
    look1(a, 0, 8'h00, "R1");           // empty tables miss
    look1(a, 0, 8'h00, "R7");
    wr(0, bh(a, 0), 0, 1, a & bm(8), 6'd8, 8'h01);
    look1(a, 1, 8'h01, "R2");
    wr(1, bh(a, 1), 1, 1, a & bm(16), 6'd16, 8'h02);
    wr(2, bh(a, 2), 3, 1, a & bm(24), 6'd24, 8'h03);
    look1(a, 1, 8'h03, "R5");
    look1(a ^ 32'h0000_0200, 1, 8'h02, "R4"); // bit 9 outside /16, inside /24
    look1(a ^ 32'h0000_0001, 1, 8'h03, "R4"); // bit 0 outside all prefixes
    look1(a ^ 32'h1000_0000, 0, 8'h00, "R4"); // bit 28 inside every prefix
    wr(1, bh(a, 1), 2, 1, a & bm(24), 6'd24, 8'h05);
    look1(a, 1, 8'h05, "R6");           // table 1 beats table 2 at equal length
    wr(1, bh(a, 1), 0, 1, a & bm(24), 6'd24, 8'h06);
    look1(a, 1, 8'h06, "R6");           // way 0 beats way 2
    wr(0, bh(a, 0), 1, 1, a, 6'd40, 8'h09);
    look1(a, 1, 8'h06, "R4");           // length 40 never matches
    wr(0, bh(a, 0), 2, 1, a, 6'd32, 8'h07);
    look1(a, 1, 8'h07, "R5");
    wr(0, bh(a, 0), 2, 0, a, 6'd32, 8'h07);
    look1(a, 1, 8'h06, "R2");           // invalidated entry gone
    a2 = 32'h0A1B_2C3D;
    wr(2, bh(a2, 2) ^ 6'h01, 0, 1, a2, 6'd32, 8'h08);
    look1(a2, 0, 8'h00, "R3");
    wr(2, bh(a2, 2), 0, 1, a2, 6'd32, 8'h08);
    look1(a2, 1, 8'h08, "R3");

    // families of nested prefixes spread over the tables
    lf = 32'h1234_5679;
    for (int f = 0; f < 16; f++) begin
      logic [31:0] b;
      int ls [4];
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      b = lf * 32'h9E37_79B1;
      ls[0] = 8 + f % 5; ls[1] = 16; ls[2] = 20 + f % 4; ls[3] = 28 + f % 5;
      for (int j = 0; j < 4; j++)
        wr((f + j) % 3, bh(b, (f + j) % 3), j, 1, b & bm(ls[j]), 6'(ls[j]), 8'(16 * f + j + 16));
      for (int i = 0; i < 16; i++)
        la[f * 16 + i] = (i == 0) ? b : b ^ (32'h1 << ((f * 7 + i * 5) % 32));
    end
    for (int i = 256; i < 320; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      la[i] = lf ^ 32'h5A5A_0000;
    end
    run_batch(320, 0);  // R8 back-to-back
    run_batch(320, 1);  // R9 with back-pressure

    // R1 reset clears entries
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    clear_model();
    k = 0;
    look1(a, 0, 8'h00, "R1");
    look1(a2, 0, 8'h00, "R1");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule